// File: doc/BRIEF.md
# Integer Register File and Single-Cycle Execute Unit

This block combines a bank of 32 general registers, each 32 bits wide, with a single-cycle execute stage for a small integer subset. The block takes one 32-bit instruction word per cycle, together with a valid flag. It splits the word into its fields and reads the two source registers through asynchronous ports. The second operand is either the second source register or a sign-extended 16-bit constant. The result is written back on the next rising clock edge.

Six operations are supported:
- three-register add, subtract and signed set-less-than;
- add-immediate;
- signed set-less-than against an immediate;
- load of a constant into the upper half of a word.

Register 0 always reads as zero, and any write to it is discarded. Arithmetic wraps and raises no exception. An unknown encoding performs no write.

The source operand values and the intended write (enable, destination, data) appear on the ports in the same cycle as the instruction. A surrounding pipeline or a bench can therefore observe the operands and the result directly.

Top module: `int_exec_core`

## Requirements
- R1: While reset is asserted, every register is cleared. After reset, both read ports return 0 for any register until that register is written.
- R2: Register 0 always reads 0. An instruction whose destination is register 0 leaves `wb_en` low, and register 0 still reads 0 afterwards.
- R3: Three-register add (opcode 0x00, funct 0x20) and subtract (opcode 0x00, funct 0x22) compute rs+rt and rs−rt modulo 2^32. The result goes to rd, and no overflow indication exists.
- R4: Add-immediate (opcode 0x08) writes rs plus the sign-extended imm[15:0] to rt, modulo 2^32.
- R5: Set-less-than (opcode 0x00, funct 0x2A) writes 1 to rd when rs < rt as signed two's-complement values, and 0 otherwise.
- R6: Set-less-than-immediate (opcode 0x0A) writes 1 to rt when rs < sign-extended imm[15:0], compared as signed values, and 0 otherwise.
- R7: Load-upper (opcode 0x0F) writes imm[15:0] into bits 31:16 of rt, with bits 15:0 set to zero.
- R8: The instruction fields are laid out as follows:

  | Field | Bits |
  |-------|------|
  | opcode | [31:26] |
  | rs | [25:21] |
  | rt | [20:16] |
  | rd | [15:11] |
  | funct | [5:0] |
  | imm | [15:0] |

  Operand and write-back outputs are combinational in the instruction's cycle. The write commits at the next rising edge, and a read in the following cycle returns the new value.
- R9: Any other opcode, or opcode 0x00 with any other funct, leaves `wb_en` low and changes no register.
- R10: When `instr_valid` is low, `wb_en` is low and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| opa_q | output | 32 | Current value of register rs |
| opb_q | output | 32 | Current value of register rt |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_addr | output | 5 | Destination register of the write |
| wb_data | output | 32 | Result to be written |

## Verification
The operand values and the write-back triple are combinational. They are due in the same cycle the instruction is presented, so the bench drives each instruction on the falling edge and samples all outputs 3 ns later, before the rising edge. The register update is due one edge later. The bench updates its own register model only after that rising edge and verifies the update through the read ports of the next instruction. Read-after-write ordering (R8), writes to register 0 and dropped writes are therefore all observed through the ports one cycle after the instruction that caused them.

// File: rtl/iexec_pkg.sv
package iexec_pkg;
  // Instruction field positions (fixed by the encoding)
  localparam int unsigned IW      = 32;
  localparam int unsigned OPC_HI  = 31;
  localparam int unsigned OPC_LO  = 26;
  localparam int unsigned RS_LO   = 21;
  localparam int unsigned RT_LO   = 16;
  localparam int unsigned RD_LO   = 11;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned RADDR_W = 5;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_LUI  = 6'h0F;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SUB = 2'd1,
    K_SLT = 2'd2,
    K_LUI = 2'd3
  } exec_kind_e;
endpackage

// File: rtl/iexec_decode.sv
module iexec_decode
  import iexec_pkg::*;
#(
  parameter int unsigned AW = RADDR_W
) (
  input  logic [IW-1:0] instr,
  input  logic          instr_valid,
  output logic [AW-1:0] src_a,
  output logic [AW-1:0] src_b,
  output logic [AW-1:0] dst,
  output exec_kind_e    kind,
  output logic          use_imm,
  output logic          illegal,
  output logic          do_write
);
  logic [5:0]      opc;
  logic [FN_W-1:0] fn;
  logic [AW-1:0]   rd_f;
  logic            unused_shamt;

  assign opc          = instr[OPC_HI:OPC_LO];
  assign fn           = instr[FN_W-1:0];
  assign src_a        = instr[RS_LO +: AW];
  assign src_b        = instr[RT_LO +: AW];
  assign rd_f         = instr[RD_LO +: AW];
  assign unused_shamt = ^instr[RD_LO-1:FN_W];

  always_comb begin
    kind    = K_ADD;
    use_imm = 1'b0;
    illegal = 1'b0;
    dst     = src_b;
    unique case (opc)
      OPC_REG: begin
        dst = rd_f;
        unique case (fn)
          FN_ADD:  kind = K_ADD;
          FN_SUB:  kind = K_SUB;
          FN_SLT:  kind = K_SLT;
          default: illegal = 1'b1;
        endcase
      end
      OPC_ADDI: begin kind = K_ADD; use_imm = 1'b1; end
      OPC_SLTI: begin kind = K_SLT; use_imm = 1'b1; end
      OPC_LUI:  begin kind = K_LUI; use_imm = 1'b1; end
      default:  illegal = 1'b1;
    endcase
  end

  // Writes to register 0 are never requested
  assign do_write = instr_valid && !illegal && (dst != '0);
endmodule

// File: rtl/iexec_alu.sv
module iexec_alu
  import iexec_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]  opa,
  input  logic [XLEN-1:0]  opb,
  input  logic [IMM_W-1:0] imm,
  input  exec_kind_e       kind,
  input  logic             use_imm,
  output logic [XLEN-1:0]  result
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] add_wrap(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return x + y;
  endfunction

  function automatic logic [XLEN-1:0] sub_wrap(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return x + ~y + 1'b1;
  endfunction

  function automatic logic [XLEN-1:0] less_signed(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    logic lt;
    if (x[XLEN-1] != y[XLEN-1]) lt = x[XLEN-1];
    else                        lt = (x[XLEN-2:0] < y[XLEN-2:0]);
    return {{(XLEN-1){1'b0}}, lt};
  endfunction

  function automatic logic [XLEN-1:0] upper_load(input logic [IMM_W-1:0] v);
    return {v, {EXT_W{1'b0}}};
  endfunction

  logic [XLEN-1:0] opb_eff;
  assign opb_eff = use_imm ? sext_imm(imm) : opb;

  always_comb begin
    unique case (kind)
      K_ADD:   result = add_wrap(opa, opb_eff);
      K_SUB:   result = sub_wrap(opa, opb_eff);
      K_SLT:   result = less_signed(opa, opb_eff);
      default: result = upper_load(imm);
    endcase
  end
endmodule

// File: rtl/iexec_regfile.sv
module iexec_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  input  logic            wen,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             regs[g] <= '0;
        else if (wen && (waddr == AW'(g)))      regs[g] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/int_exec_core.sv
module int_exec_core
  import iexec_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [IW-1:0]   instr,
  output logic [XLEN-1:0] opa_q,
  output logic [XLEN-1:0] opb_q,
  output logic            wb_en,
  output logic [AW-1:0]   wb_addr,
  output logic [XLEN-1:0] wb_data
);
  logic [AW-1:0] src_a, src_b, dst;
  exec_kind_e    kind;
  logic          use_imm, dec_write;

  // Named internal events for the checker
  logic ev_illegal, ev_cmp, ev_lui;

  iexec_decode #(.AW(AW)) u_dec (
    .instr(instr), .instr_valid(instr_valid),
    .src_a(src_a), .src_b(src_b), .dst(dst),
    .kind(kind), .use_imm(use_imm), .illegal(ev_illegal), .do_write(dec_write)
  );

  iexec_regfile #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .raddr_a(src_a), .raddr_b(src_b), .rdata_a(opa_q), .rdata_b(opb_q),
    .wen(wb_en), .waddr(wb_addr), .wdata(wb_data)
  );

  iexec_alu #(.XLEN(XLEN)) u_alu (
    .opa(opa_q), .opb(opb_q), .imm(instr[IMM_W-1:0]),
    .kind(kind), .use_imm(use_imm), .result(wb_data)
  );

  assign ev_cmp  = (kind == K_SLT) && !ev_illegal;
  assign ev_lui  = (kind == K_LUI) && !ev_illegal;
  assign wb_en   = rst_n && dec_write;
  assign wb_addr = dst;
endmodule

// File: rtl/iexec_checker.sv
module iexec_checker #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] opa_q,
  input logic [XLEN-1:0] opb_q,
  input logic            wb_en,
  input logic [AW-1:0]   wb_addr,
  input logic [XLEN-1:0] wb_data,
  input logic            ev_illegal,
  input logic            ev_cmp,
  input logic            ev_lui
);
  assert_zero_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[25:21] == '0) |-> (opa_q == '0));

  assert_no_zero_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_addr != '0));

  assert_cmp_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |-> (wb_data[XLEN-1:1] == '0));

  assert_lui_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lui |-> (wb_data[15:0] == '0));

  assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wb_en) && (instr[20:16] == $past(wb_addr))) |-> (opb_q == $past(wb_data)));

  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_illegal |-> !wb_en);

  assert_invalid_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !wb_en);
endmodule

bind int_exec_core iexec_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
  .opa_q(opa_q), .opb_q(opb_q), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
  .ev_illegal(ev_illegal), .ev_cmp(ev_cmp), .ev_lui(ev_lui)
);

// File: tb/int_exec_core_test.sv
module int_exec_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] opa_q, opb_q, wb_data;
  logic        wb_en;
  logic [4:0]  wb_addr;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  int_exec_core uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .opa_q(opa_q), .opb_q(opb_q), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] k);
    return {op, 5'(rs), 5'(rt), k};
  endfunction

  // Independent prediction of the write-back from the requirements
  task automatic predict(input logic v, input logic [31:0] ins,
                         output logic we, output logic [4:0] wa, output logic [31:0] wd);
    logic [31:0] a, b, kx;
    logic ok;
    a  = model[ins[25:21]];
    b  = model[ins[20:16]];
    kx = 32'($signed(ins[15:0]));
    ok = 1'b1;
    wa = ins[20:16];
    wd = '0;
    case (ins[31:26])
      6'h00: begin
        wa = ins[15:11];
        case (ins[5:0])
          6'h20:   wd = a + b;
          6'h22:   wd = a - b;
          6'h2A:   wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ok = 1'b0;
        endcase
      end
      6'h08:   wd = a + kx;
      6'h0A:   wd = ($signed(a) < $signed(kx)) ? 32'd1 : 32'd0;
      6'h0F:   wd = ins[15:0] * 32'h10000;
      default: ok = 1'b0;
    endcase
    we = v && ok && (wa != 5'd0);
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] ins, input string tag);
    logic we;
    logic [4:0] wa;
    logic [31:0] wd;
    @(negedge clk);
    instr_valid = v;
    instr = ins;
    #3;
    predict(v, ins, we, wa, wd);
    chk({tag, "/R8"}, "opa", opa_q, model[ins[25:21]]);
    chk({tag, "/R8"}, "opb", opb_q, model[ins[20:16]]);
    chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, we});
    if (we) begin
      chk(tag, "wb_addr", {27'd0, wb_addr}, {27'd0, wa});
      chk(tag, "wb_data", wb_data, wd);
    end
    @(posedge clk);
    if (we) model[wa] = wd;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0417));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers read zero after reset (valid low also covers R10)
    for (int i = 0; i < 32; i++) issue(1'b0, enc_r(6'h20, i, 31 - i, 1), "R1");

    // Directed corners
    issue(1'b1, enc_i(6'h08, 0, 1, 16'hFFFF), "R4");   // r1 = -1
    issue(1'b1, enc_i(6'h0F, 0, 2, 16'h7FFF), "R7");   // r2 = 0x7FFF0000
    issue(1'b1, enc_i(6'h0F, 0, 3, 16'h8000), "R7");   // r3 = 0x80000000
    issue(1'b1, enc_i(6'h08, 2, 4, 16'h8000), "R4");   // negative imm
    issue(1'b1, enc_r(6'h20, 3, 3, 5), "R3");          // wraps to 0
    issue(1'b1, enc_r(6'h22, 0, 1, 6), "R3");          // 0 - (-1) = 1
    issue(1'b1, enc_r(6'h22, 3, 6, 7), "R3");          // min - 1 wraps
    issue(1'b1, enc_r(6'h2A, 3, 0, 8), "R5");          // min < 0 -> 1
    issue(1'b1, enc_r(6'h2A, 0, 3, 9), "R5");          // 0 < min -> 0
    issue(1'b1, enc_r(6'h2A, 1, 1, 9), "R5");          // equal -> 0
    issue(1'b1, enc_i(6'h0A, 1, 10, 16'h0000), "R6");  // -1 < 0 -> 1
    issue(1'b1, enc_i(6'h0A, 0, 11, 16'hFFFF), "R6");  // 0 < -1 -> 0
    issue(1'b1, enc_i(6'h0A, 2, 12, 16'h7FFF), "R6");  // large < small -> 0
    issue(1'b1, enc_i(6'h08, 1, 0, 16'h0005), "R2");   // write to r0 dropped
    issue(1'b1, enc_r(6'h20, 1, 1, 0), "R2");
    issue(1'b1, enc_r(6'h20, 0, 0, 13), "R2");         // r0 still reads 0
    issue(1'b1, enc_i(6'h3F, 1, 2, 16'h1234), "R9");   // unknown opcode
    issue(1'b1, enc_r(6'h21, 1, 1, 2), "R9");          // unknown funct
    issue(1'b1, enc_r(6'h20, 2, 2, 14), "R9");         // r2 unchanged
    issue(1'b0, enc_i(6'h08, 1, 2, 16'h0001), "R10");  // invalid
    issue(1'b1, enc_r(6'h20, 2, 0, 15), "R10");        // r2 unchanged
    issue(1'b1, enc_i(6'h08, 15, 15, 16'h0001), "R8"); // back-to-back RAW
    issue(1'b1, enc_r(6'h20, 15, 15, 15), "R8");

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int sel, rs, rt, rd;
      logic [15:0] k;
      sel = $urandom_range(0, 8);
      rs  = $urandom_range(0, 31);
      rt  = $urandom_range(0, 31);
      rd  = $urandom_range(0, 31);
      k   = 16'($urandom);
      case (sel)
        0: issue(1'b1, enc_r(6'h20, rs, rt, rd), "R3");
        1: issue(1'b1, enc_r(6'h22, rs, rt, rd), "R3");
        2: issue(1'b1, enc_r(6'h2A, rs, rt, rd), "R5");
        3: issue(1'b1, enc_i(6'h08, rs, rt, k), "R4");
        4: issue(1'b1, enc_i(6'h0A, rs, rt, k), "R6");
        5: issue(1'b1, enc_i(6'h0F, rs, rt, k), "R7");
        6: issue(1'b1, enc_i(6'h23, rs, rt, k), "R9");
        7: issue(1'b1, enc_r(6'h2B, rs, rt, rd), "R9");
        default: issue(1'b0, enc_r(6'h20, rs, rt, rd), "R10");
      endcase
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule